// File: doc/BRIEF.md
# Register Write-Enable Unlock Sequencer

This block guards a small bank of nonvolatile control registers against accidental change. It sits behind a serial target front end. That front end reports decoded bus events: transaction start, transaction stop, each received byte with its position in the transaction, and a flag for a malformed bit count. Position 0 is always the target byte, and its least significant bit marks a read.

Two latches form the lock. A write-enable latch is set by a first status write. A register-write latch is set by a second status write, and only while the first latch is already set. With both latches set, a single burst of register bytes is accepted. The stop that ends the burst starts a timed nonvolatile write cycle, which a busy flag shows. When that cycle finishes, both latches drop, so the unlock must be repeated before every change.

Writes to the main storage array pass through a block-protect decoder. A three-bit code held in one of the control registers selects the protected range. The block emits one array write strobe for each accepted data byte, and none for a protected address.

Top module: `rwu_unlock_seq`

## Requirements
- R1: After reset, the write-enable latch (`wel`), the register-write latch (`rwel`), `busy` and `arr_we` are all 0, and every register reads back 00h.
- R2: A well-formed status write sets `wel` and leaves `rwel` unchanged. A well-formed status write is: target AEh at position 0, address 3Fh at position 1, exactly one data byte of 02h at position 2, then a stop.
- R3: A well-formed status write of 06h sets `rwel` and keeps `wel` set, but only if `wel` was already set. A status data byte of any other value with a stray bit, such as 07h, changes neither latch.
- R4: A well-formed status write of 00h clears both `wel` and `rwel`.
- R5: A malformed status transaction changes neither latch, and in particular leaves a set `rwel` set. Malformed means any of: a repeated start before the stop, a byte count other than three, a position index that skips, or the bit-error flag raised during the transaction.
- R6: A read transaction (target byte with LSB 1) that falls between the two unlock writes does not disturb the latches or the sequence.
- R7: With `rwel` set and `busy` low, a register write is accepted. Such a write is target DEh at position 0, a register address at position 1, and 1 to MAXB data bytes at positions 2 onward, then a stop. The data bytes land in consecutive registers starting at the address, and the stop raises `busy`.
- R8: `busy` stays high for exactly BUSY_CYC cycles. On the cycle it falls, both `wel` and `rwel` are 0.
- R9: Data bytes aimed at register addresses of NUM_REGS or above are dropped, and those addresses read back 00h. Bytes of the same burst aimed at defined addresses still land.
- R10: A register write made while `rwel` is clear is discarded, and the registers keep their values.
- R11: A register write that arrives while `busy` is high is discarded, even though `rwel` is still set.
- R12: A register burst that carries more than MAXB data bytes is discarded entirely, and it starts no busy cycle.
- R13: An array write is target A0h, address high byte at position 1, address low byte at position 2, and data from position 3 onward. Each data byte gives one `arr_we` pulse in the cycle after the byte, at an address that increments from the start address. The pulse is suppressed when the address is protected. Protection is set by the code in bits 4:2 of register 7, over an 11-bit array: 000 none; 001 600h–7FFh; 010 400h–7FFh; 011 all; 100 000h–03Fh; 101 000h–07Fh; 110 000h–0FFh; 111 000h–1FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | Start or repeated start seen (one-cycle pulse) |
| ev_stop | input | 1 | Stop seen (one-cycle pulse) |
| ev_byte_vld | input | 1 | A received byte is presented |
| ev_byte | input | 8 | Received byte value |
| ev_byte_idx | input | IDXW | Position of the byte in the transaction, 0 = target byte |
| ev_err | input | 1 | Bit-count error seen in the current transaction |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Register contents at `rd_addr`, 00h if undefined |
| wel | output | 1 | Write-enable latch |
| rwel | output | 1 | Register-write-enable latch |
| busy | output | 1 | Nonvolatile write cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | AW | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The hardest situation to reach from the ports is a second register burst that arrives while a write cycle is still running. At that moment `rwel` is still high, so only `busy` should block the write. To get there, the bench unlocks, launches a burst, and sends a second burst at once, well inside the busy window. It then waits out the cycle and reads the register back. The bench also covers an abort that comes after `rwel` is already set. It replays a clearing status write that is cut short by a repeated start, and checks that the latch survives. For the protection decoder, a single two-byte array burst straddles each range edge, so one strobe is allowed and its neighbour is blocked.

// File: rtl/rwu_pkg.sv
package rwu_pkg;

   // Returns 1 when address a falls inside the range selected by code bp
   // for an array of 2**aw bytes.
   function automatic logic bp_blocks(input logic [2:0] bp, input logic [15:0] a,
                                      input int aw);
      int span;
      int ai;
      span = 1 << aw;
      ai   = int'(a);
      case (bp)
         3'b001:  return ai >= span - span / 4;
         3'b010:  return ai >= span / 2;
         3'b011:  return 1'b1;
         3'b100:  return ai < 64;
         3'b101:  return ai < 128;
         3'b110:  return ai < 256;
         3'b111:  return ai < 512;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/rwu_frame.sv
module rwu_frame #(
   parameter int IDXW = 4,
   parameter int MAXB = 8,
   parameter logic [7:0] ARR_TGT = 8'hA0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ev_start,
   input  logic                 ev_stop,
   input  logic                 ev_byte_vld,
   input  logic [7:0]           ev_byte,
   input  logic [IDXW-1:0]      ev_byte_idx,
   input  logic                 ev_err,
   output logic                 done,
   output logic [7:0]           tgt,
   output logic [7:0]           addr_a,
   output logic [7:0]           addr_b,
   output logic [IDXW-1:0]      cnt,
   output logic [MAXB-1:0][7:0] dbuf,
   output logic                 arr_req,
   output logic [IDXW-1:0]      arr_off
);
   localparam int BW = (MAXB > 1) ? $clog2(MAXB) : 1;
   localparam logic [IDXW-1:0] CNT_MAX = '1;

   logic in_txn, bad;
   logic good_byte;

   assign good_byte = in_txn && !bad && ev_byte_vld && !ev_err && (ev_byte_idx == cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_txn <= 1'b0;
         bad    <= 1'b0;
         cnt    <= '0;
         tgt    <= '0;
         addr_a <= '0;
         addr_b <= '0;
         dbuf   <= '0;
      end else if (ev_start) begin
         in_txn <= 1'b1;
         bad    <= 1'b0;
         cnt    <= '0;
      end else if (ev_stop) begin
         in_txn <= 1'b0;
      end else if (in_txn) begin
         if (ev_err) bad <= 1'b1;
         if (ev_byte_vld) begin
            if (ev_byte_idx != cnt) bad <= 1'b1;
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            case (cnt)
               IDXW'(0): tgt    <= ev_byte;
               IDXW'(1): addr_a <= ev_byte;
               IDXW'(2): addr_b <= ev_byte;
               default: ;
            endcase
            if (cnt >= IDXW'(2) && (cnt - IDXW'(2)) < IDXW'(MAXB))
               dbuf[BW'(cnt - IDXW'(2))] <= ev_byte;
         end
      end
   end

   assign done    = ev_stop && !ev_start && in_txn && !bad && !ev_err;
   assign arr_req = good_byte && !ev_start && !ev_stop && cnt >= IDXW'(3) && tgt == ARR_TGT;
   assign arr_off = cnt - IDXW'(3);
endmodule

// File: rtl/rwu_nvtimer.sv
module rwu_nvtimer #(
   parameter int BUSY_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   output logic busy,
   output logic fin
);
   localparam int CW = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;

   logic [CW-1:0] left;

   assign fin = busy && left == '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         left <= '0;
      end else if (launch && !busy) begin
         busy <= 1'b1;
         left <= CW'(BUSY_CYC - 1);
      end else if (fin) begin
         busy <= 1'b0;
      end else if (busy) begin
         left <= left - 1'b1;
      end
   end
endmodule

// File: rtl/rwu_unlock_seq.sv
module rwu_unlock_seq #(
   parameter int         NUM_REGS  = 8,
   parameter int         MAXB      = 8,
   parameter int         AW        = 11,
   parameter int         IDXW      = 4,
   parameter int         BUSY_CYC  = 64,
   parameter int         BP_REG    = 7,
   parameter logic [7:0] STAT_TGT  = 8'hAE,
   parameter logic [7:0] STAT_ADDR = 8'h3F,
   parameter logic [7:0] CCR_TGT   = 8'hDE,
   parameter logic [7:0] ARR_TGT   = 8'hA0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ev_start,
   input  logic            ev_stop,
   input  logic            ev_byte_vld,
   input  logic [7:0]      ev_byte,
   input  logic [IDXW-1:0] ev_byte_idx,
   input  logic            ev_err,
   input  logic [7:0]      rd_addr,
   output logic [7:0]      rd_data,
   output logic            wel,
   output logic            rwel,
   output logic            busy,
   output logic            arr_we,
   output logic [AW-1:0]   arr_addr,
   output logic [7:0]      arr_wdata
);
   import rwu_pkg::*;

   localparam int BW = (MAXB > 1) ? $clog2(MAXB) : 1;
   localparam logic [IDXW-1:0] CCR_MAX_CNT = IDXW'(MAXB + 2);

   initial begin
      assert (AW >= 10 && AW <= 16) else $error("AW out of range");
      assert (NUM_REGS >= 1 && NUM_REGS <= 256) else $error("NUM_REGS out of range");
      assert (BP_REG < NUM_REGS) else $error("BP_REG outside bank");
      assert (MAXB + 3 < (1 << IDXW)) else $error("IDXW too narrow for MAXB");
      assert (BUSY_CYC >= 2) else $error("BUSY_CYC too small");
   end

   logic                 done, arr_req, fin, launch;
   logic [7:0]           tgt, addr_a, addr_b;
   logic [IDXW-1:0]      cnt, arr_off, nd;
   logic [MAXB-1:0][7:0] dbuf;
   logic [7:0]           bank [NUM_REGS];
   logic [NUM_REGS*8-1:0] bank_flat;
   logic [2:0]           bp;
   logic                 stat_ok, ccr_ok;
   logic [AW-1:0]        arr_next;

   rwu_frame #(.IDXW(IDXW), .MAXB(MAXB), .ARR_TGT(ARR_TGT)) u_frame (
      .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
      .ev_byte_vld(ev_byte_vld), .ev_byte(ev_byte), .ev_byte_idx(ev_byte_idx),
      .ev_err(ev_err), .done(done), .tgt(tgt), .addr_a(addr_a), .addr_b(addr_b),
      .cnt(cnt), .dbuf(dbuf), .arr_req(arr_req), .arr_off(arr_off)
   );

   rwu_nvtimer #(.BUSY_CYC(BUSY_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy), .fin(fin)
   );

   assign nd      = cnt - IDXW'(2);
   assign stat_ok = done && tgt == STAT_TGT && addr_a == STAT_ADDR && cnt == IDXW'(3);
   assign ccr_ok  = done && tgt == CCR_TGT && cnt >= IDXW'(3) && cnt <= CCR_MAX_CNT;
   assign launch  = ccr_ok && rwel && !busy;

   // Lock latches: cycle completion clears first, a status write applies after it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel  <= 1'b0;
         rwel <= 1'b0;
      end else begin
         if (fin) begin
            wel  <= 1'b0;
            rwel <= 1'b0;
         end
         if (stat_ok) begin
            case (dbuf[0])
               8'h02: wel <= 1'b1;
               8'h06: if (wel && !fin) begin
                  wel  <= 1'b1;
                  rwel <= 1'b1;
               end
               8'h00: begin
                  wel  <= 1'b0;
                  rwel <= 1'b0;
               end
               default: ;
            endcase
         end
      end
   end

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         localparam logic [7:0] RADDR = 8'(i);
         logic [7:0] off;
         logic       hit;
         assign off = RADDR - addr_a;
         assign hit = launch && RADDR >= addr_a && off < 8'(nd);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   bank[i] <= '0;
            else if (hit) bank[i] <= dbuf[BW'(off)];
         end
         assign bank_flat[i*8 +: 8] = bank[i];
      end
   endgenerate

   assign bp      = bank[BP_REG][4:2];
   assign rd_data = (int'(rd_addr) < NUM_REGS) ? bank[rd_addr] : 8'h00;

   assign arr_next = AW'({addr_a, addr_b}) + AW'(arr_off);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arr_we    <= 1'b0;
         arr_addr  <= '0;
         arr_wdata <= '0;
      end else begin
         arr_we <= arr_req && !bp_blocks(bp, 16'(arr_next), AW);
         if (arr_req) begin
            arr_addr  <= arr_next;
            arr_wdata <= ev_byte;
         end
      end
   end
endmodule

// File: rtl/rwu_unlock_chk.sv
module rwu_unlock_chk #(
   parameter int AW       = 11,
   parameter int NUM_REGS = 8,
   parameter int BUSY_CYC = 64
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wel,
   input logic                  rwel,
   input logic                  busy,
   input logic                  arr_we,
   input logic [AW-1:0]         arr_addr,
   input logic [2:0]            bp,
   input logic [NUM_REGS*8-1:0] bank_flat
);
   int busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     busy_len <= 0;
      else if (!busy) busy_len <= 0;
      else            busy_len <= busy_len + 1;
   end

   // R3: the register-write latch never stands without the write-enable latch
   a_r3_rwel_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
      rwel |-> wel);

   // R7: a write cycle only starts from an unlocked state
   a_r7_launch_needs_rwel: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(rwel));

   // R8: both latches are down when the cycle ends
   a_r8_fall_clears_latches: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (!rwel && !wel));

   // R8: the busy window never exceeds its length
   a_r8_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> busy_len < BUSY_CYC);

   // R11: register contents hold while a cycle runs
   a_r11_bank_stable_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(bank_flat));

   // R13: full protection blocks every array strobe
   a_r13_full_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (bp == 3'b011 && $past(bp) == 3'b011) |-> !arr_we);

   // R13: upper-quarter protection keeps strobes below the boundary
   a_r13_upper_quarter: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && $past(bp) == 3'b001) |-> (int'(arr_addr) < (3 << (AW - 2))));
endmodule

bind rwu_unlock_seq rwu_unlock_chk #(.AW(AW), .NUM_REGS(NUM_REGS), .BUSY_CYC(BUSY_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .wel(wel), .rwel(rwel), .busy(busy),
   .arr_we(arr_we), .arr_addr(arr_addr), .bp(bp), .bank_flat(bank_flat)
);

// File: tb/sim_rwu_unlock_seq.sv
module sim_rwu_unlock_seq;
   localparam int CLK_PERIOD = 10;
   localparam int BUSY_CYC   = 64;
   localparam int IDXW       = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_start = 0, ev_stop = 0, ev_byte_vld = 0, ev_err = 0;
   logic [7:0] ev_byte = 0;
   logic [IDXW-1:0] ev_byte_idx = 0;
   logic [7:0] rd_addr = 0;
   logic [7:0] rd_data;
   logic wel, rwel, busy, arr_we;
   logic [10:0] arr_addr;
   logic [7:0] arr_wdata;

   int nchk = 0, nfail = 0;
   logic [7:0] msg [16];
   logic        seen_we [16];
   logic [10:0] seen_addr [16];

   always #(CLK_PERIOD/2) clk = ~clk;

   rwu_unlock_seq #(.BUSY_CYC(BUSY_CYC)) u0 (
      .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
      .ev_byte_vld(ev_byte_vld), .ev_byte(ev_byte), .ev_byte_idx(ev_byte_idx),
      .ev_err(ev_err), .rd_addr(rd_addr), .rd_data(rd_data), .wel(wel),
      .rwel(rwel), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
      .arr_wdata(arr_wdata)
   );

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // mode 0: stop, 1: repeated start instead of stop, 2: bit error on last byte
   task automatic frame(input int n, input int mode);
      @(negedge clk) ev_start = 1;
      @(negedge clk) ev_start = 0;
      for (int i = 0; i < n; i++) begin
         ev_byte_vld = 1; ev_byte = msg[i]; ev_byte_idx = IDXW'(i);
         ev_err = (mode == 2 && i == n - 1);
         @(negedge clk) ev_byte_vld = 0; ev_err = 0;
         seen_we[i] = arr_we; seen_addr[i] = arr_addr;
      end
      if (mode == 1) ev_start = 1; else ev_stop = 1;
      @(negedge clk) ev_start = 0; ev_stop = 0;
   endtask

   task automatic stat_wr(input logic [7:0] v, input int mode);
      msg[0] = 8'hAE; msg[1] = 8'h3F; msg[2] = v;
      frame(3, mode);
   endtask

   task automatic unlock();
      stat_wr(8'h02, 0);
      stat_wr(8'h06, 0);
   endtask

   task automatic ccr_wr1(input logic [7:0] a, input logic [7:0] d);
      msg[0] = 8'hDE; msg[1] = a; msg[2] = d;
      frame(3, 0);
   endtask

   task automatic wait_idle();
      repeat (BUSY_CYC + 2) @(negedge clk);
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      rd_addr = a; #1; d = rd_data;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 wel", wel, 0); chk("R1 rwel", rwel, 0);
      chk("R1 busy", busy, 0); chk("R1 arr_we", arr_we, 0);
      rd(8'h03, d); chk("R1 reg3", d, 0);
   endtask

   task automatic t_latches();
      stat_wr(8'h06, 0);
      chk("R3 06 without wel", rwel, 0);
      chk("R3 06 without wel keeps wel low", wel, 0);
      stat_wr(8'h02, 0);
      chk("R2 wel set", wel, 1); chk("R2 rwel unchanged", rwel, 0);
      stat_wr(8'h07, 0);
      chk("R3 stray bit ignored", rwel, 0);
      stat_wr(8'h06, 0);
      chk("R3 rwel set", rwel, 1); chk("R3 wel kept", wel, 1);
      stat_wr(8'h00, 0);
      chk("R4 rwel cleared", rwel, 0); chk("R4 wel cleared", wel, 0);
   endtask

   task automatic t_malformed();
      stat_wr(8'h02, 1);
      chk("R5 restart no wel", wel, 0);
      stat_wr(8'h02, 2);
      chk("R5 bit error no wel", wel, 0);
      msg[0] = 8'hAE; msg[1] = 8'h3F; msg[2] = 8'h02; msg[3] = 8'h02;
      frame(4, 0);
      chk("R5 extra byte no wel", wel, 0);
      unlock();
      stat_wr(8'h00, 1);
      chk("R5 restart keeps rwel", rwel, 1);
      msg[0] = 8'hAE; msg[1] = 8'h3F;
      frame(2, 0);
      chk("R5 short frame keeps rwel", rwel, 1);
      stat_wr(8'h00, 0);
      chk("R4 clear after aborts", rwel, 0);
   endtask

   task automatic t_read_between();
      stat_wr(8'h02, 0);
      msg[0] = 8'hAF; msg[1] = 8'h3F; msg[2] = 8'h06;
      frame(3, 0);
      chk("R6 read keeps wel", wel, 1);
      stat_wr(8'h06, 0);
      chk("R6 unlock completes", rwel, 1);
      stat_wr(8'h00, 0);
   endtask

   task automatic t_burst();
      logic [7:0] d;
      ccr_wr1(8'h01, 8'h5A);
      rd(8'h01, d); chk("R10 locked write discarded", d, 0);
      chk("R10 no busy", busy, 0);
      unlock();
      msg[0] = 8'hDE; msg[1] = 8'h00; msg[2] = 8'h11; msg[3] = 8'h22; msg[4] = 8'h33;
      frame(5, 0);
      chk("R7 busy raised", busy, 1);
      rd(8'h00, d); chk("R7 reg0", d, 8'h11);
      rd(8'h01, d); chk("R7 reg1", d, 8'h22);
      rd(8'h02, d); chk("R7 reg2", d, 8'h33);
      repeat (BUSY_CYC - 1) @(negedge clk);
      chk("R8 busy at last cycle", busy, 1);
      chk("R8 rwel held while busy", rwel, 1);
      @(negedge clk);
      chk("R8 busy ended", busy, 0);
      chk("R8 rwel cleared", rwel, 0); chk("R8 wel cleared", wel, 0);
      ccr_wr1(8'h00, 8'hEE);
      rd(8'h00, d); chk("R10 needs new unlock", d, 8'h11);
   endtask

   task automatic t_busy_ignore();
      logic [7:0] d;
      unlock();
      ccr_wr1(8'h04, 8'h44);
      ccr_wr1(8'h05, 8'h99);
      wait_idle();
      rd(8'h04, d); chk("R11 first write", d, 8'h44);
      rd(8'h05, d); chk("R11 write during busy ignored", d, 0);
   endtask

   task automatic t_undef_and_long();
      logic [7:0] d;
      unlock();
      msg[0] = 8'hDE; msg[1] = 8'h07; msg[2] = 8'h03; msg[3] = 8'h77;
      frame(4, 0);
      wait_idle();
      rd(8'h07, d); chk("R9 defined part lands", d, 8'h03);
      rd(8'h08, d); chk("R9 undefined reads zero", d, 0);
      unlock();
      msg[0] = 8'hDE; msg[1] = 8'h00;
      for (int i = 2; i < 11; i++) msg[i] = 8'hC0 + 8'(i);
      frame(11, 0);
      chk("R12 no busy", busy, 0);
      rd(8'h00, d); chk("R12 reg0 unchanged", d, 8'h11);
      chk("R12 rwel kept", rwel, 1);
      stat_wr(8'h00, 0);
   endtask

   task automatic set_bp(input logic [2:0] code);
      unlock();
      ccr_wr1(8'h07, {3'b000, code, 2'b00});
      wait_idle();
   endtask

   task automatic arr_pair(input logic [10:0] a, input string tag,
                           input int exp0, input int exp1);
      msg[0] = 8'hA0; msg[1] = {5'b0, a[10:8]}; msg[2] = a[7:0];
      msg[3] = 8'h5C; msg[4] = 8'hC5;
      frame(5, 0);
      chk({tag, " first we"}, seen_we[3], exp0);
      chk({tag, " second we"}, seen_we[4], exp1);
      if (exp1 == 1) chk({tag, " second addr"}, seen_addr[4], int'(a) + 1);
      if (exp0 == 1) chk({tag, " first addr"}, seen_addr[3], int'(a));
   endtask

   task automatic t_protect();
      arr_pair(11'h7FE, "R13 bp000", 1, 1);
      set_bp(3'b001);
      arr_pair(11'h5FF, "R13 bp001 edge", 1, 0);
      set_bp(3'b100);
      arr_pair(11'h03F, "R13 bp100 edge", 0, 1);
      set_bp(3'b011);
      arr_pair(11'h000, "R13 bp011", 0, 0);
      set_bp(3'b010);
      arr_pair(11'h3FF, "R13 bp010 edge", 1, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++; nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latches();
      t_malformed();
      t_read_between();
      t_burst();
      t_busy_ignore();
      t_undef_and_long();
      t_protect();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule